// File: doc/BRIEF.md
# JTAG Debug Access Scan Port

This block is the JTAG side of a debug port. A TAP controller clocked by TCK drives a 4-bit instruction register. The instruction selects one of three 35-bit scan registers: debug-port access, access-port access and abort. Any other instruction selects a 1-bit bypass path. A single scan of an access register carries two things. It shifts in a new request: write data, a 2-bit register address and a read/write flag. At the same time it shifts out the result of the earlier transaction: the read buffer and a 3-bit acknowledge.

Debug-port registers are held inside the block, and an access to them completes in the Update-DR cycle. Access-port requests go to a backend as a one-cycle valid pulse with a 6-bit address. That address joins a bank field from the internal bank-select register with the shifted address bits. Only one access-port request can be outstanding at a time. A request that arrives while one is outstanding is dropped and answered with WAIT. A write of 1 to the abort register releases a stuck transaction.

Top module: `jtag_dap_scan`

## Requirements
- R1: Five TCK cycles with TMS high reach Test-Logic-Reset from any state. Test-Logic-Reset, or trst_n low, loads the bypass instruction 1111. It also clears the bank-select register, the control register, the read buffer, the outstanding request and the WAIT state.
- R2: Instruction 1010 selects debug-port access, 1011 selects access-port access and 1000 selects abort. Every other code selects a 1-bit bypass register, which captures 0. Capture-IR loads 0001.
- R3: Scans shift LSB first. TDI is sampled on the rising TCK edge. TDO changes on the falling edge and is 0 outside Shift-IR and Shift-DR.
- R4: The incoming access word holds write data in bits 34:3, the register address in bits 2:1 and the read flag in bit 0 (1 = read, 0 = write).
- R5: Capture-DR of an access or abort instruction loads the read buffer into bits 34:3 and an acknowledge into bits 2:0. The acknowledge is 010 (OK) or 001 (WAIT) and never any other code.
- R6: A read issued at Update-DR shows its data in the next scan, not in the scan that issued it.
- R7: Debug-port address 01 is a 32-bit read/write control register and address 10 is the bank-select register. Addresses 00 and 11 read as 0 and ignore writes.
- R8: An accepted access-port request raises req_valid for exactly the cycle after Update-DR. In that cycle req_addr = {bank-select bits 7:4, A[3:2]}, and req_rnw and req_wdata come from the shifted word.
- R9: A request stays outstanding until rsp_valid. A read response is stored in the read buffer, and a write response leaves the buffer unchanged. rsp_valid while nothing is outstanding is ignored.
- R10: An Update-DR of debug-port or access-port access while a request is outstanding is discarded, with no req_valid and no register change. The next Capture-DR then loads WAIT. A Capture-DR that happens while a request is outstanding also loads WAIT.
- R11: A response arriving on the Capture-DR edge is not seen by that capture: the scan returns WAIT with the old buffer. The Update-DR of the same scan is accepted, and the following scan returns OK with the new data.
- R12: In the abort scan, scan bit 3 (register bit 0) at 1 gives a one-cycle abort_pulse after Update-DR and clears the outstanding request and the WAIT state. All other bits are ignored, and with bit 3 at 0 nothing happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| req_valid | output | 1 | One-cycle access-port request strobe |
| req_rnw | output | 1 | Request is a read |
| req_addr | output | 6 | Bank and register address of the request |
| req_wdata | output | 32 | Write data of the request |
| rsp_valid | input | 1 | Backend completion strobe |
| rsp_rdata | input | 32 | Read data returned with rsp_valid |
| abort_pulse | output | 1 | One-cycle abort strobe |

## Verification
Two functions can fall on the same TCK edge: a backend response completing, and Capture-DR loading the acknowledge and read buffer for shifting out. The bench raises rsp_valid exactly in the Capture-DR cycle of an access scan. It then expects WAIT with the old buffer in that scan, an accepted request at its Update-DR, and OK with the new data in the scan after. A second overlap is an Update-DR that meets an outstanding request. That case is judged by the missing req_valid and by the WAIT returned in the following scan.

// File: rtl/jtag_dap_scan.sv
module jtag_dap_scan #(
  parameter int DW       = 32,
  parameter int BANKW    = 4,
  parameter int BANK_LSB = 4
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               req_valid,
  output logic               req_rnw,
  output logic [BANKW+1:0]   req_addr,
  output logic [DW-1:0]      req_wdata,
  input  logic               rsp_valid,
  input  logic [DW-1:0]      rsp_rdata,
  output logic               abort_pulse
);
  localparam int SW = DW + 3;
  localparam logic [3:0] IR_DP  = 4'b1010;
  localparam logic [3:0] IR_AP  = 4'b1011;
  localparam logic [3:0] IR_ABT = 4'b1000;
  localparam logic [3:0] IR_BYP = 4'b1111;
  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  typedef enum logic [3:0] {
    EX2DR = 4'h0, EX1DR = 4'h1, SHDR = 4'h2, PAUSDR = 4'h3,
    SELIR = 4'h4, UPDDR = 4'h5, CAPDR = 4'h6, SELDR = 4'h7,
    EX2IR = 4'h8, EX1IR = 4'h9, SHIR = 4'hA, PAUSIR = 4'hB,
    RTI   = 4'hC, UPDIR = 4'hD, CAPIR = 4'hE, TLR   = 4'hF
  } tap_e;

  tap_e state, nxt;
  logic [3:0]    ir, ir_sr;
  logic [SW-1:0] sr;
  logic [DW-1:0] ctrl, sel, rdbuf;
  logic          busy, pend_rnw, wait_flag;

  always_comb begin
    case (state)
      TLR:    nxt = tms ? TLR   : RTI;
      RTI:    nxt = tms ? SELDR : RTI;
      SELDR:  nxt = tms ? SELIR : CAPDR;
      CAPDR:  nxt = tms ? EX1DR : SHDR;
      SHDR:   nxt = tms ? EX1DR : SHDR;
      EX1DR:  nxt = tms ? UPDDR : PAUSDR;
      PAUSDR: nxt = tms ? EX2DR : PAUSDR;
      EX2DR:  nxt = tms ? UPDDR : SHDR;
      UPDDR:  nxt = tms ? SELDR : RTI;
      SELIR:  nxt = tms ? TLR   : CAPIR;
      CAPIR:  nxt = tms ? EX1IR : SHIR;
      SHIR:   nxt = tms ? EX1IR : SHIR;
      EX1IR:  nxt = tms ? UPDIR : PAUSIR;
      PAUSIR: nxt = tms ? EX2IR : PAUSIR;
      EX2IR:  nxt = tms ? UPDIR : SHIR;
      default: nxt = tms ? SELDR : RTI;
    endcase
  end

  wire           is_dp  = (ir == IR_DP);
  wire           is_ap  = (ir == IR_AP);
  wire           is_abt = (ir == IR_ABT);
  wire           is_acc = is_dp | is_ap;
  wire [1:0]     sh_a   = sr[2:1];
  wire           sh_rnw = sr[0];
  wire [DW-1:0]  sh_dat = sr[SW-1:3];
  wire [DW-1:0]  dp_rd  = (sh_a == 2'b01) ? ctrl : (sh_a == 2'b10) ? sel : '0;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state <= TLR;      ir <= IR_BYP;  ir_sr <= '0;  sr <= '0;
      ctrl <= '0;        sel <= '0;     rdbuf <= '0;
      busy <= 1'b0;      pend_rnw <= 1'b0;  wait_flag <= 1'b0;
      req_valid <= 1'b0; req_rnw <= 1'b0;   req_addr <= '0;  req_wdata <= '0;
      abort_pulse <= 1'b0;
    end else begin
      state       <= nxt;
      req_valid   <= 1'b0;
      abort_pulse <= 1'b0;
      if (busy && rsp_valid) begin
        busy <= 1'b0;
        if (pend_rnw) rdbuf <= rsp_rdata;
      end
      case (state)
        TLR: begin
          ir <= IR_BYP; sel <= '0; ctrl <= '0; rdbuf <= '0;
          busy <= 1'b0; wait_flag <= 1'b0;
        end
        CAPIR: ir_sr <= 4'b0001;
        SHIR:  ir_sr <= {tdi, ir_sr[3:1]};
        UPDIR: ir <= ir_sr;
        CAPDR: begin
          if (is_acc || is_abt) begin
            sr <= {rdbuf, (busy || wait_flag) ? ACK_WAIT : ACK_OK};
            wait_flag <= 1'b0;
          end else begin
            sr[0] <= 1'b0;
          end
        end
        SHDR: begin
          if (is_acc || is_abt) sr <= {tdi, sr[SW-1:1]};
          else sr[0] <= tdi;
        end
        UPDDR: begin
          if (is_abt) begin
            if (sr[3]) begin
              abort_pulse <= 1'b1;
              busy        <= 1'b0;
              wait_flag   <= 1'b0;
            end
          end else if (is_acc) begin
            if (busy) begin
              wait_flag <= 1'b1;
            end else if (is_ap) begin
              req_valid <= 1'b1;
              req_rnw   <= sh_rnw;
              req_addr  <= {sel[BANK_LSB+BANKW-1:BANK_LSB], sh_a};
              req_wdata <= sh_dat;
              busy      <= 1'b1;
              pend_rnw  <= sh_rnw;
            end else if (sh_rnw) begin
              rdbuf <= dp_rd;
            end else if (sh_a == 2'b01) begin
              ctrl <= sh_dat;
            end else if (sh_a == 2'b10) begin
              sel <= sh_dat;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else if (state == SHIR) tdo <= ir_sr[0];
    else if (state == SHDR) tdo <= sr[0];
    else tdo <= 1'b0;
  end
endmodule

// File: rtl/jtag_dap_scan_chk.sv
module jtag_dap_scan_chk #(
  parameter int DW = 32
) (
  input logic          tck,
  input logic          trst_n,
  input logic [3:0]    state,
  input logic [3:0]    ir,
  input logic [DW-1:0] sel,
  input logic          busy,
  input logic [DW+2:0] sr,
  input logic          req_valid,
  input logic          abort_pulse
);
  localparam logic [3:0] S_TLR = 4'hF;
  localparam logic [3:0] S_CAPDR = 4'h6;
  localparam logic [3:0] S_UPDDR = 4'h5;

  p_tlr_clear_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> (ir == 4'b1111 && sel == '0 && !busy));

  p_ack_legal_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAPDR && (ir == 4'b1010 || ir == 4'b1011 || ir == 4'b1000))
      |=> (sr[2:0] == 3'b010 || sr[2:0] == 3'b001));

  p_req_one_cycle_r8: assert property (@(posedge tck) disable iff (!trst_n)
    req_valid |=> !req_valid);

  p_req_after_update_r8: assert property (@(posedge tck) disable iff (!trst_n)
    req_valid |-> ($past(state) == S_UPDDR));

  p_no_req_while_busy_r10: assert property (@(posedge tck) disable iff (!trst_n)
    req_valid |-> !$past(busy));

  p_abort_one_cycle_r12: assert property (@(posedge tck) disable iff (!trst_n)
    abort_pulse |=> !abort_pulse);

  p_abort_frees_r12: assert property (@(posedge tck) disable iff (!trst_n)
    abort_pulse |-> !busy);
endmodule

bind jtag_dap_scan jtag_dap_scan_chk #(.DW(DW)) u_chk (
  .tck(tck), .trst_n(trst_n), .state(state), .ir(ir), .sel(sel), .busy(busy),
  .sr(sr), .req_valid(req_valid), .abort_pulse(abort_pulse)
);

// File: tb/jtag_dap_scan_bench.sv
module jtag_dap_scan_bench;
  localparam logic [2:0] OK = 3'b010;
  localparam logic [2:0] WT = 3'b001;
  localparam logic [3:0] I_DP = 4'b1010, I_AP = 4'b1011, I_AB = 4'b1000;

  logic tck = 1'b0;
  logic trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, req_valid, req_rnw, abort_pulse, rsp_valid = 1'b0;
  logic [5:0]  req_addr;
  logic [31:0] req_wdata, rsp_rdata = '0;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2 tck = ~tck;

  jtag_dap_scan u_jtag_dap_scan (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .req_valid(req_valid), .req_rnw(req_rnw), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .abort_pulse(abort_pulse)
  );

  // {shift-in word, expected shift-out word}, debug-port instruction
  localparam logic [69:0] VEC [11] = '{
    {32'h12345678, 2'b01, 1'b0, 32'h00000000, OK},
    {32'h00000000, 2'b01, 1'b1, 32'h00000000, OK},
    {32'h00000000, 2'b10, 1'b1, 32'h12345678, OK},
    {32'h000000A0, 2'b10, 1'b0, 32'h00000000, OK},
    {32'hFFFFFFFF, 2'b00, 1'b0, 32'h00000000, OK},
    {32'hDEADBEEF, 2'b11, 1'b0, 32'h00000000, OK},
    {32'h00000000, 2'b00, 1'b1, 32'h00000000, OK},
    {32'h00000000, 2'b11, 1'b1, 32'h00000000, OK},
    {32'h00000000, 2'b10, 1'b1, 32'h00000000, OK},
    {32'h00000000, 2'b01, 1'b1, 32'h000000A0, OK},
    {32'h00000000, 2'b01, 1'b0, 32'h12345678, OK}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic scan_ir(input logic [3:0] v, output logic [3:0] o);
    o = '0;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge tck); #1; o[i] = tdo;
      tick(i == 3, v[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input logic [34:0] v, input int n, input bit cap_rsp,
                         input logic [31:0] cap_data, output logic [34:0] o);
    o = '0;
    tick(1, 0); tick(0, 0);
    if (cap_rsp) begin rsp_valid = 1'b1; rsp_rdata = cap_data; end
    tick(0, 0);
    rsp_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1; o[i] = tdo;
      tick(i == n - 1, v[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic respond(input logic [31:0] d);
    rsp_valid = 1'b1; rsp_rdata = d;
    @(posedge tck); #1;
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      done = 1; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [3:0]  io;
    logic [34:0] o;
    repeat (3) @(posedge tck);
    #1;
    chk("R1 reset req_valid", req_valid, 0);
    chk("R1 reset abort_pulse", abort_pulse, 0);
    chk("R3 reset tdo", tdo, 0);
    trst_n = 1'b1;
    tick(0, 0);

    scan_dr(35'b10110101, 8, 0, 0, o);
    chk("R1 R2 bypass after reset", o[7:0], 8'b01101010);
    @(negedge tck); #1;
    chk("R3 tdo idle in run-test", tdo, 0);

    scan_ir(I_DP, io);
    chk("R2 capture-IR pattern", io, 4'b0001);

    for (int k = 0; k < 11; k++) begin
      scan_dr(VEC[k][69:35], 35, 0, 0, o);
      chk($sformatf("R4 R5 R6 R7 vector %0d", k), o, VEC[k][34:0]);
    end

    scan_ir(I_AP, io);
    scan_dr({32'hCAFEF00D, 2'b11, 1'b0}, 35, 0, 0, o);
    chk("R5 ap write scan out", o, {32'h12345678, OK});
    chk("R8 req_valid", req_valid, 1);
    chk("R8 req_rnw", req_rnw, 0);
    chk("R8 req_addr bank+A", req_addr, 6'b101011);
    chk("R8 req_wdata", req_wdata, 32'hCAFEF00D);
    tick(0, 0);
    chk("R8 req_valid one cycle", req_valid, 0);
    respond(32'h11111111);

    scan_dr({32'h0, 2'b01, 1'b1}, 35, 0, 0, o);
    chk("R9 write response leaves buffer", o, {32'h12345678, OK});
    chk("R8 read req_rnw", req_rnw, 1);
    chk("R8 read req_addr", req_addr, 6'b101001);
    scan_dr({32'h0, 2'b10, 1'b1}, 35, 0, 0, o);
    chk("R10 wait while outstanding", o, {32'h12345678, WT});
    chk("R10 discarded no req_valid", req_valid, 0);
    respond(32'hBEEF0001);
    scan_dr({32'h0, 2'b00, 1'b0}, 35, 0, 0, o);
    chk("R10 wait after discard, R9 data stored", o, {32'hBEEF0001, WT});
    chk("R10 request accepted again", req_valid, 1);
    respond(32'h0);

    scan_dr({32'h0, 2'b10, 1'b1}, 35, 0, 0, o);
    chk("R6 R9 ok with read data", o, {32'hBEEF0001, OK});
    scan_dr({32'h0, 2'b00, 1'b0}, 35, 1, 32'h5A5A5A5A, o);
    chk("R11 response at capture gives wait", o, {32'hBEEF0001, WT});
    chk("R11 same scan update accepted", req_valid, 1);
    respond(32'h0);
    scan_ir(I_DP, io);
    scan_dr({32'h0, 2'b00, 1'b1}, 35, 0, 0, o);
    chk("R11 next scan ok new data", o, {32'h5A5A5A5A, OK});

    respond(32'h77777777);
    scan_dr({32'h0, 2'b00, 1'b1}, 35, 0, 0, o);
    chk("R9 idle response ignored", o, {32'h0, OK});

    scan_ir(I_AP, io);
    scan_dr({32'h0, 2'b00, 1'b1}, 35, 0, 0, o);
    scan_ir(I_AB, io);
    scan_dr({31'h7FFFFFFF, 1'b0, 3'b111}, 35, 0, 0, o);
    chk("R12 bit3 clear no abort", abort_pulse, 0);
    chk("R5 abort scan shows wait", o, {32'h0, WT});
    scan_dr({32'h1, 3'b000}, 35, 0, 0, o);
    chk("R12 abort pulse", abort_pulse, 1);
    tick(0, 0);
    chk("R12 abort one cycle", abort_pulse, 0);
    scan_ir(I_DP, io);
    scan_dr({32'h0, 2'b00, 1'b1}, 35, 0, 0, o);
    chk("R12 abort cleared outstanding", o, {32'h0, OK});

    scan_ir(I_AP, io);
    scan_dr({32'h0, 2'b01, 1'b1}, 35, 0, 0, o);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    scan_dr(35'b0110, 4, 0, 0, o);
    chk("R1 bypass after TMS reset", o[3:0], 4'b1100);
    scan_ir(I_DP, io);
    scan_dr({32'h0, 2'b10, 1'b1}, 35, 0, 0, o);
    chk("R1 outstanding cleared", o, {32'h0, OK});
    scan_dr({32'h0, 2'b00, 1'b1}, 35, 0, 0, o);
    chk("R1 bank-select cleared", o, {32'h0, OK});

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule